// File: doc/BRIEF.md
# PHY Tuning Serial Write Sequencer

This block loads tuning values into the hidden configuration bits of a USB PHY. The PHY is reached through one shared control word. That word carries an 8-bit address field, a single data bit and one write strobe for each port. A request names a port, a start address, a data word and a bit count. The sequencer then shifts the data out one bit at a time, least significant bit first. Each bit goes to the next consecutive address and is latched into the PHY by a one-clock pulse on that port's strobe.

Each bit takes four clocks. The first clock places the address. The second sets the data bit and clears the strobe. The third raises the strobe and the fourth drops it. A build-time option inserts one extra clock that zeroes the whole control word before the first bit. Some PHY generations need this. Every update is a read-modify-write of the word the block holds, so fields that a step does not touch keep their values between requests.

Typical loads are short: a one-bit calibration enable, a five-bit amplitude and slew setting, a two-bit disconnect threshold and a two-bit squelch setting.

Top module: `phy_tune_seq`

## Requirements
- R1: After reset the control word is all zeros, busy and done are low and req_ready is high.
- R2: A request is taken only when req_valid and req_ready are both high, and req_ready is high only while idle. A request presented while busy changes neither the running sequence nor the control word, and produces no extra done.
- R3: During bit i of a request, control word bits 15:8 carry the start address plus i, modulo 256.
- R4: Control word bit 7 carries bit i of the request data, so data leaves least significant bit first.
- R5: The strobe of port n is control word bit 2*n. Within each bit it is high for exactly one clock, and no two strobes are ever high together.
- R6: Each bit is four clocks, in this order: address write, then data set with strobe low, then strobe high, then strobe low. Bits 15:7 do not change while a strobe is high.
- R7: With the clear option enabled, the whole control word is zero for the clock that follows acceptance, before the first address write. Without the option, the first address write comes in that clock.
- R8: done is high for exactly one clock, in the clock in which the last strobe falls. busy is high from the clock after acceptance until that clock. A request with a bit count of zero writes nothing and raises done in the clock right after acceptance.
- R9: Control word bits other than the address field, the data bit and the selected strobe keep their previous values. Strobes of other ports never rise, and bits above 15 stay zero.
- R10: A bit count larger than MAX_BITS is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_port | input | PORT_W | Target port index |
| req_addr | input | 8 | Address of the first bit |
| req_data | input | MAX_BITS | Data, least significant bit sent first |
| req_len | input | CNT_W | Number of bits (0 to MAX_BITS, larger values clamped) |
| busy | output | 1 | A request is being sequenced |
| done | output | 1 | One-clock pulse at the end of a request |
| ctrl_word | output | CTRL_W | Registered PHY control word |

## Verification
The bench builds the default sizes twice: four ports, a 32-bit word and up to eight bits per request. One copy has the clear option off and the other has it on, and both receive the same requests, so the two timings are compared on identical stimulus. With only four ports and counts from zero to nine, every port is swept against every bit count, including the empty request and the clamped ones. Three data patterns and an address that wraps past 0xFF are included. The expected word is rebuilt step by step in the bench and compared on every clock, so stale fields, stray strobes and the extra clear clock all show up directly.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  // Field positions inside the PHY control word (fixed by the PHY's decoding)
  localparam int ADDR_W   = 8;
  localparam int ADDR_LSB = 8;
  localparam int DATA_POS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ADDR,
    ST_DATA,
    ST_STRB_HI,
    ST_STRB_LO
  } step_e;
endpackage

// File: rtl/phy_tune_ctrl.sv
module phy_tune_ctrl
  import phy_tune_pkg::*;
#(
  parameter int MAX_BITS    = 8,
  parameter bit CLEAR_FIRST = 1'b0,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_len,
  output logic             req_ready,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output step_e            step,
  output logic [CNT_W-1:0] bit_idx
);
  step_e            step_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] idx_q;
  logic             done_q;
  logic [CNT_W-1:0] eff_len;

  assign eff_len   = (req_len > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : req_len;
  assign req_ready = (step_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign busy      = (step_q != ST_IDLE);
  assign done      = done_q;
  assign step      = step_q;
  assign bit_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      len_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (step_q)
        ST_IDLE: begin
          if (accept) begin
            idx_q <= '0;
            len_q <= eff_len;
            if (eff_len == '0) done_q <= 1'b1;
            else step_q <= CLEAR_FIRST ? ST_CLEAR : ST_ADDR;
          end
        end
        ST_CLEAR:   step_q <= ST_ADDR;
        ST_ADDR:    step_q <= ST_DATA;
        ST_DATA:    step_q <= ST_STRB_HI;
        ST_STRB_HI: step_q <= ST_STRB_LO;
        ST_STRB_LO: begin
          if (idx_q == len_q - 1'b1) begin
            step_q <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q  <= idx_q + 1'b1;
            step_q <= ST_ADDR;
          end
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_tune_strb.sv
module phy_tune_strb #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int CTRL_W    = 32
) (
  input  logic [PORT_W-1:0] port,
  output logic [CTRL_W-1:0] mask
);
  // Port n owns bit 2*n of the control word
  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if ((b % 2 == 0) && (b / 2 < NUM_PORTS)) begin : g_strb
      assign mask[b] = (port == PORT_W'(b / 2));
    end else begin : g_none
      assign mask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/phy_tune_word.sv
module phy_tune_word
  import phy_tune_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dbit,
  input  logic [CTRL_W-1:0] strb_mask,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic [CTRL_W-1:0] word_q;
  assign ctrl_word = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else begin
      case (step)
        ST_CLEAR:   word_q <= '0;
        ST_ADDR:    word_q[ADDR_LSB +: ADDR_W] <= addr;
        ST_DATA: begin
          word_q           <= word_q & ~strb_mask;
          word_q[DATA_POS] <= dbit;
        end
        ST_STRB_HI: word_q <= word_q | strb_mask;
        ST_STRB_LO: word_q <= word_q & ~strb_mask;
        default:    word_q <= word_q;
      endcase
    end
  end
endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int CTRL_W      = 32,
  parameter int MAX_BITS    = 8,
  parameter bit CLEAR_FIRST = 1'b0,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PORT_W-1:0]   req_port,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [MAX_BITS-1:0] req_data,
  input  logic [CNT_W-1:0]    req_len,
  output logic                busy,
  output logic                done,
  output logic [CTRL_W-1:0]   ctrl_word
);
  logic                accept;
  step_e               step;
  logic [CNT_W-1:0]    bit_idx;
  logic [PORT_W-1:0]   lat_port;
  logic [ADDR_W-1:0]   lat_addr;
  logic [MAX_BITS-1:0] lat_data;
  logic [MAX_BITS-1:0] data_sh;
  logic [ADDR_W-1:0]   cur_addr;
  logic [CTRL_W-1:0]   strb_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_port <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else if (accept) begin
      lat_port <= req_port;
      lat_addr <= req_addr;
      lat_data <= req_data;
    end
  end

  assign cur_addr = lat_addr + ADDR_W'(bit_idx);
  assign data_sh  = lat_data >> bit_idx;

  phy_tune_ctrl #(
    .MAX_BITS(MAX_BITS), .CLEAR_FIRST(CLEAR_FIRST), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .accept(accept), .busy(busy), .done(done),
    .step(step), .bit_idx(bit_idx)
  );

  phy_tune_strb #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .CTRL_W(CTRL_W)
  ) u_strb (
    .port(lat_port), .mask(strb_mask)
  );

  phy_tune_word #(.CTRL_W(CTRL_W)) u_word (
    .clk(clk), .rst(rst), .step(step), .addr(cur_addr),
    .dbit(data_sh[0]), .strb_mask(strb_mask), .ctrl_word(ctrl_word)
  );
endmodule

// File: rtl/phy_tune_seq_chk.sv
module phy_tune_seq_chk #(
  parameter int NUM_PORTS = 4,
  parameter int CTRL_W    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [CTRL_W-1:0] ctrl_word
);
  logic [NUM_PORTS-1:0] strb;
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) strb[p] = ctrl_word[2*p];
  end

  assert_strb_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  assert_strb_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (|strb) |=> !(|strb));

  assert_fields_held_R6: assert property (@(posedge clk) disable iff (rst)
    (|strb) |-> $stable(ctrl_word[15:7]));

  assert_idle_word_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(ctrl_word));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  if (CTRL_W > 16) begin : g_upper
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
      ctrl_word[CTRL_W-1:16] == '0);
  end
endmodule

bind phy_tune_seq phy_tune_seq_chk #(.NUM_PORTS(NUM_PORTS), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ctrl_word(ctrl_word)
);

// File: tb/phy_tune_seq_tb.sv
module phy_tune_seq_tb;
  localparam int NP = 4;
  localparam int CW = 32;
  localparam int MB = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_port = '0;
  logic [7:0]    req_addr = '0;
  logic [MB-1:0] req_data = '0;
  logic [3:0]    req_len = '0;

  logic          rdy_a, busy_a, done_a, rdy_b, busy_b, done_b;
  logic [CW-1:0] word_a, word_b;
  logic [CW-1:0] ma = '0, mb = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  phy_tune_seq #(.NUM_PORTS(NP), .CTRL_W(CW), .MAX_BITS(MB), .CLEAR_FIRST(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_a),
    .req_port(req_port), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .busy(busy_a), .done(done_a), .ctrl_word(word_a));

  phy_tune_seq #(.NUM_PORTS(NP), .CTRL_W(CW), .MAX_BITS(MB), .CLEAR_FIRST(1'b1)) u_dut_clr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_b),
    .req_port(req_port), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .busy(busy_b), .done(done_b), .ctrl_word(word_b));

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One step of the per-bit sequence, rebuilt from the requirements (R3-R6)
  function automatic logic [CW-1:0] step_model(input logic [CW-1:0] w, input int s,
      input int port, input logic [7:0] addr, input logic [MB-1:0] data);
    int ph = s % 4;
    int bi = s / 4;
    logic [7:0] a = addr + 8'(bi);
    case (ph)
      0: w[15:8] = a;
      1: begin w[7] = data[bi]; w[2*port] = 1'b0; end
      2: w[2*port] = 1'b1;
      default: w[2*port] = 1'b0;
    endcase
    return w;
  endfunction

  task automatic run(input int port, input logic [7:0] addr, input logic [MB-1:0] data,
                     input int len, input bit junk, input string tag);
    int eff = (len > MB) ? MB : len;
    int done_a_at = 4 * eff;
    int done_b_at = (eff == 0) ? 0 : 4 * eff + 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_port  = 2'(port);
    req_addr  = addr;
    req_data  = data;
    req_len   = 4'(len);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_port = 2'(port ^ 1);
      req_addr = ~addr;
      req_data = ~data;
      req_len  = 4'd3;
    end else begin
      req_valid = 1'b0;
    end
    for (int j = 0; j <= done_b_at + 1; j++) begin
      if (j == 3) req_valid = 1'b0;
      if (j >= 1 && j - 1 < 4 * eff) ma = step_model(ma, j - 1, port, addr, data);
      if (eff > 0 && j == 1) mb = '0;
      if (eff > 0 && j >= 2 && j - 2 < 4 * eff) mb = step_model(mb, j - 2, port, addr, data);
      if (j <= done_a_at + 1)
        chk($sformatf("%s port=%0d len=%0d sample=%0d", tag, port, len, j),
            {busy_a, done_a, word_a}, {(j < done_a_at), (j == done_a_at), ma});
      chk($sformatf("R7 %s port=%0d len=%0d sample=%0d", tag, port, len, j),
          {busy_b, done_b, word_b}, {(eff > 0 && j < done_b_at), (j == done_b_at), mb});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [MB-1:0] pats [3] = '{8'h14, 8'hA5, 8'h5A};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 dut", {busy_a, done_a, word_a}, 34'd0);
    chk("R1 dut_clr", {busy_b, done_b, word_b}, 34'd0);
    chk("R1 ready", {32'd0, rdy_a, rdy_b}, {32'd0, 2'b11});

    // Typical tuning loads
    run(0, 8'h0C, 8'h01, 1, 1'b0, "R3 R4 R5 R6 cal");
    run(1, 8'h20, 8'h14, 5, 1'b0, "R3 R4 R5 R6 amp");
    run(2, 8'h2A, 8'h02, 2, 1'b0, "R3 R4 R5 R6 thr");
    run(3, 8'h3C, 8'h02, 2, 1'b0, "R3 R4 R5 R6 sq");

    // Sweep: every port against every count, several data patterns
    for (int p = 0; p < NP; p++)
      for (int l = 0; l < 10; l++)
        for (int d = 0; d < 3; d++)
          run(p, 8'h20 + 8'(p * 16 + d), pats[d], l, 1'b0,
              (l == 0) ? "R8 empty" : (l > MB) ? "R10 clamp" : "R3 R4 R5 R6 R9 sweep");

    // R3: address wraps modulo 256
    run(2, 8'hFE, 8'hC9, 5, 1'b0, "R3 wrap");
    // R10: largest count code
    run(1, 8'h70, 8'h96, 15, 1'b0, "R10 max");
    // R2: request held with other contents while busy is ignored
    run(1, 8'h40, 8'hC3, 3, 1'b1, "R2 busy");
    run(3, 8'h50, 8'h3C, 2, 1'b1, "R2 busy");
    chk("R2 ready after", {32'd0, rdy_a, rdy_b}, {32'd0, 2'b11});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule